// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block tracks up to 32 PCI slots for firmware-driven hotplug. It holds three per-slot masks: slot present, slot hotplug-capable and slot pending removal. Per-slot event inputs report a hot insertion, a hot removal request or a device found at power-up. A hot insertion or a hot removal request raises a one-cycle set pulse on a general-purpose event status bit, which the event logic block downstream latches.

Software sees a window of four aligned 32-bit registers. A read of the insertion word returns the slots that are present and hotplug-capable. The removal word returns the pending removals, and the removable word returns the hotplug-capable mask. Software completes a removal by writing the eject word. Each eject write retires only the lowest slot named in the written value. That slot's present bit is cleared unless a fixed device sits in the slot.

Device configuration and bus enumeration are outside the block. They appear only as per-slot "occupied" and "fixed device" inputs.

Top module: `slot_hotplug_regs`

## Requirements
- R1: While `rst_n` is low, on each clock the block clears the pending-removal mask and loads the hotplug-capable mask with the inverse of `slot_fixed`. It loads the present mask from `slot_occupied` and drives `gpe_set` to 0. Any pending removal is therefore complete once reset ends.
- R2: A full read at offset 0x0 returns present AND hotplug-capable, in the same cycle and with no wait state.
- R3: A full read at offset 0x4 returns the pending-removal mask. A full read at 0x8 returns 0. A full read at 0xC returns the hotplug-capable mask.
- R4: A `plug_evt` bit sets that slot's present bit at the next clock edge. One cycle later, `gpe_set` equals 0x02 (bit 1 set) for one cycle per event cycle.
- R5: An `unplug_evt` bit sets that slot's pending-removal bit at the next clock edge, and `gpe_set` equals 0x02 in the following cycle.
- R6: A `cold_evt` bit sets that slot's present bit and leaves `gpe_set` at 0.
- R7: A full write at offset 0x8 clears only the lowest set bit of the written value in the pending-removal mask.
- R8: The same eject write clears that slot's present bit only when the slot's `slot_fixed` input is 0.
- R9: An eject write of 0 changes no state.
- R10: Full writes at offsets 0x0, 0x4 and 0xC change no state.
- R11: An access is full only when all four `req_be` bits are set and `req_addr[1:0]` is 0. Any other access returns 0 on a read and changes no state on a write.
- R12: When an event and an eject write hit the same slot in one cycle, the event wins: the bit it sets is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset inside the window |
| req_be | input | 4 | Byte enables; all must be set for a full access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, 0 when no full read |
| slot_occupied | input | 32 | Slots holding a device, sampled during reset |
| slot_fixed | input | 32 | Slots holding a non-hotpluggable device |
| plug_evt | input | 32 | Per-slot hot insertion event |
| unplug_evt | input | 32 | Per-slot hot removal request |
| cold_evt | input | 32 | Per-slot device found at power-up |
| gpe_set | output | 8 | One-cycle set pulses for event status bits |

## Verification
A behavioural model runs alongside the block and is compared with it on every clock. The stimulus starts with plug, cold and unplug events on separate slots; together these separate the present mask from the removal mask, and a status-raising event from a silent one. Eject writes then carry several bits, zero, or bits on fixed and on free slots, which shows that only the lowest bit is retired and that the fixed-device guard holds. Writes at read-only offsets, partial or misaligned accesses, same-cycle event/eject collisions and a second reset with removals still pending cover the remaining corners.

// File: rtl/shp_pkg.sv
package shp_pkg;
   // Word selector inside the window; software depends on this order.
   typedef enum logic [1:0] {
      SEL_INSERT = 2'd0,
      SEL_REMOVE = 2'd1,
      SEL_EJECT  = 2'd2,
      SEL_RMVBL  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/shp_lsb_isolate.sv
module shp_lsb_isolate #(
   parameter int W     = 32,
   parameter bit ARITH = 1'b1
) (
   input  logic [W-1:0] vec,
   output logic [W-1:0] onehot
);
   if (W < 1) begin : g_bad_w
      $error("shp_lsb_isolate: W must be at least 1");
   end

   if (ARITH) begin : g_arith
      // Two's complement trick: one carry chain.
      assign onehot = vec & (~vec + W'(1));
   end else begin : g_chain
      // Priority chain: one gate per bit, no adder.
      logic [W:0] seen;
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign onehot[i]  = vec[i] & ~seen[i];
         assign seen[i+1]  = seen[i] | vec[i];
      end
   end
endmodule

// File: rtl/shp_reg_decode.sv
module shp_reg_decode
   import shp_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W/8-1:0]  req_be,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [NUM_SLOTS-1:0] present,
   input  logic [NUM_SLOTS-1:0] hp_en,
   input  logic [NUM_SLOTS-1:0] down,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 eject_we,
   output logic [NUM_SLOTS-1:0] eject_val
);
   localparam int BE_W = DATA_W / 8;
   localparam int LSB  = $clog2(BE_W);

   if (ADDR_W != LSB + 2) begin : g_bad_addr
      $error("shp_reg_decode: ADDR_W must cover exactly four words");
   end

   logic     full_acc;
   reg_sel_e sel;

   assign full_acc  = req_valid && (&req_be) && (req_addr[LSB-1:0] == '0);
   assign sel       = reg_sel_e'(req_addr[LSB+1:LSB]);
   assign eject_we  = full_acc && req_write && (sel == SEL_EJECT);
   assign eject_val = req_wdata[NUM_SLOTS-1:0];

   always_comb begin
      rd_data = '0;
      if (full_acc && !req_write) begin
         unique case (sel)
            SEL_INSERT: rd_data[NUM_SLOTS-1:0] = present & hp_en;
            SEL_REMOVE: rd_data[NUM_SLOTS-1:0] = down;
            SEL_EJECT:  rd_data = '0;
            SEL_RMVBL:  rd_data[NUM_SLOTS-1:0] = hp_en;
         endcase
      end
   end
endmodule

// File: rtl/shp_slot_bank.sv
module shp_slot_bank #(
   parameter int NUM_SLOTS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] occupied,
   input  logic [NUM_SLOTS-1:0] fixed_dev,
   input  logic [NUM_SLOTS-1:0] plug,
   input  logic [NUM_SLOTS-1:0] unplug,
   input  logic [NUM_SLOTS-1:0] cold,
   input  logic                 eject_we,
   input  logic [NUM_SLOTS-1:0] eject_onehot,
   output logic [NUM_SLOTS-1:0] present_q,
   output logic [NUM_SLOTS-1:0] hp_en_q,
   output logic [NUM_SLOTS-1:0] down_q
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = eject_we & eject_onehot[s];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            // Pending removals complete; masks rebuilt from the bus view.
            down_q[s]    <= 1'b0;
            hp_en_q[s]   <= ~fixed_dev[s];
            present_q[s] <= occupied[s];
         end else begin
            // Events are applied after the eject clear, so they win.
            down_q[s]    <= (down_q[s] & ~hit) | unplug[s];
            present_q[s] <= (present_q[s] & ~(hit & ~fixed_dev[s]))
                            | plug[s] | cold[s];
         end
      end
   end
endmodule

// File: rtl/slot_hotplug_regs.sv
module slot_hotplug_regs #(
   parameter int NUM_SLOTS  = 32,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int GPE_W      = 8,
   parameter int HP_GPE_BIT = 1,
   parameter bit LSB_ARITH  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W/8-1:0]  req_be,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [NUM_SLOTS-1:0] slot_occupied,
   input  logic [NUM_SLOTS-1:0] slot_fixed,
   input  logic [NUM_SLOTS-1:0] plug_evt,
   input  logic [NUM_SLOTS-1:0] unplug_evt,
   input  logic [NUM_SLOTS-1:0] cold_evt,
   output logic [GPE_W-1:0]     gpe_set
);
   if (DATA_W != 32) begin : g_bad_data
      $error("slot_hotplug_regs: only 32-bit registers are supported");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > DATA_W) begin : g_bad_slots
      $error("slot_hotplug_regs: NUM_SLOTS must be 1..DATA_W");
   end
   if (HP_GPE_BIT < 0 || HP_GPE_BIT >= GPE_W) begin : g_bad_gpe
      $error("slot_hotplug_regs: HP_GPE_BIT outside gpe_set");
   end

   localparam logic [GPE_W-1:0] HP_MASK = GPE_W'(1) << HP_GPE_BIT;

   logic [NUM_SLOTS-1:0] present_q, hp_en_q, down_q;
   logic [NUM_SLOTS-1:0] eject_val, eject_onehot;
   logic                 eject_we;
   logic [GPE_W-1:0]     gpe_q;

   shp_reg_decode #(
      .NUM_SLOTS (NUM_SLOTS),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .present   (present_q),
      .hp_en     (hp_en_q),
      .down      (down_q),
      .rd_data   (rd_data),
      .eject_we  (eject_we),
      .eject_val (eject_val)
   );

   shp_lsb_isolate #(
      .W     (NUM_SLOTS),
      .ARITH (LSB_ARITH)
   ) u_lsb (
      .vec    (eject_val),
      .onehot (eject_onehot)
   );

   shp_slot_bank #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .occupied     (slot_occupied),
      .fixed_dev    (slot_fixed),
      .plug         (plug_evt),
      .unplug       (unplug_evt),
      .cold         (cold_evt),
      .eject_we     (eject_we),
      .eject_onehot (eject_onehot),
      .present_q    (present_q),
      .hp_en_q      (hp_en_q),
      .down_q       (down_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         gpe_q <= '0;
      else
         gpe_q <= (|(plug_evt | unplug_evt)) ? HP_MASK : '0;
   end

   assign gpe_set = gpe_q;
endmodule

// File: rtl/shp_checker.sv
module shp_checker #(
   parameter int NUM_SLOTS  = 32,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int GPE_W      = 8,
   parameter int HP_GPE_BIT = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [ADDR_W-1:0]    req_addr,
   input logic [DATA_W/8-1:0]  req_be,
   input logic [DATA_W-1:0]    req_wdata,
   input logic [DATA_W-1:0]    rd_data,
   input logic [NUM_SLOTS-1:0] plug_evt,
   input logic [NUM_SLOTS-1:0] unplug_evt,
   input logic [NUM_SLOTS-1:0] cold_evt,
   input logic [GPE_W-1:0]     gpe_set,
   input logic [NUM_SLOTS-1:0] present_q,
   input logic [NUM_SLOTS-1:0] down_q
);
   logic full_wr, quiet;
   assign full_wr = req_valid && req_write && (&req_be) && (req_addr[1:0] == 2'b00);
   assign quiet   = (plug_evt == '0) && (unplug_evt == '0) && (cold_evt == '0);

   AST_GPE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(plug_evt | unplug_evt)) |=> gpe_set[HP_GPE_BIT]); // R4
   AST_GPE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(plug_evt | unplug_evt)) |=> (gpe_set == '0)); // R6
   AST_PLUG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (plug_evt != '0) |=> ((present_q & $past(plug_evt)) == $past(plug_evt))); // R4
   AST_UNPLUG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (unplug_evt != '0) |=> ((down_q & $past(unplug_evt)) == $past(unplug_evt))); // R5
   AST_EJECT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && req_addr[3:2] == 2'd2 && quiet) |=> ($countones($past(down_q) & ~down_q) <= 1)); // R7
   AST_EJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && req_addr[3:2] == 2'd2 && req_wdata[NUM_SLOTS-1:0] == '0 && quiet)
      |=> ($stable(down_q) && $stable(present_q))); // R9
   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && req_addr[3:2] != 2'd2 && quiet) |=> ($stable(down_q) && $stable(present_q))); // R10
   AST_EJECT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[3:2] == 2'd2) |-> (rd_data == '0)); // R3
endmodule

bind slot_hotplug_regs shp_checker #(
   .NUM_SLOTS  (NUM_SLOTS),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .GPE_W      (GPE_W),
   .HP_GPE_BIT (HP_GPE_BIT)
) u_shp_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .req_be     (req_be),
   .req_wdata  (req_wdata),
   .rd_data    (rd_data),
   .plug_evt   (plug_evt),
   .unplug_evt (unplug_evt),
   .cold_evt   (cold_evt),
   .gpe_set    (gpe_set),
   .present_q  (present_q),
   .down_q     (down_q)
);

// File: tb/tb_slot_hotplug_regs.sv
module tb_slot_hotplug_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_addr = '0, req_be = '0;
   logic [31:0] req_wdata = '0, rd_data;
   logic [31:0] slot_occupied = '0, slot_fixed = '0;
   logic [31:0] plug_evt = '0, unplug_evt = '0, cold_evt = '0;
   logic [7:0]  gpe_set;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_present, m_hp, m_down;
   logic [7:0]  m_gpe;

   always #10 clk = ~clk;

   slot_hotplug_regs dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rd_data(rd_data),
      .slot_occupied(slot_occupied), .slot_fixed(slot_fixed), .plug_evt(plug_evt),
      .unplug_evt(unplug_evt), .cold_evt(cold_evt), .gpe_set(gpe_set)
   );

   function automatic bit is_full();
      return req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
   endfunction

   function automatic logic [31:0] model_read();
      if (!is_full() || req_write) return 32'h0;
      case (req_addr[3:2])
         2'd0: return m_present & m_hp;
         2'd1: return m_down;
         2'd2: return 32'h0;
         default: return m_hp;
      endcase
   endfunction

   task automatic model_step();
      logic [31:0] ej;
      ej = '0;
      if (!rst_n) begin
         m_down = '0; m_hp = ~slot_fixed; m_present = slot_occupied; m_gpe = '0;
         return;
      end
      if (is_full() && req_write && req_addr[3:2] == 2'd2) begin
         for (int i = 0; i < 32; i++)
            if (req_wdata[i]) begin ej[i] = 1'b1; break; end
      end
      m_down    = (m_down & ~ej) | unplug_evt;
      m_present = (m_present & ~(ej & ~slot_fixed)) | plug_evt | cold_evt;
      m_gpe     = ((plug_evt | unplug_evt) != 0) ? 8'h02 : 8'h00;
   endtask

   // One clock: drive, compare outputs against the model, advance.
   task automatic cyc(input string req, input logic v, input logic w,
                      input logic [3:0] a, input logic [3:0] be, input logic [31:0] wd,
                      input logic [31:0] pl, input logic [31:0] ul, input logic [31:0] cl);
      logic [31:0] exp_rd;
      req_valid = v; req_write = w; req_addr = a; req_be = be; req_wdata = wd;
      plug_evt = pl; unplug_evt = ul; cold_evt = cl;
      #1;
      if (rst_n) begin
         exp_rd = model_read();
         checks++;
         if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, exp_rd);
         end
         checks++;
         if (gpe_set !== m_gpe) begin
            errors++;
            $display("FAIL %s gpe_set actual=%h expected=%h", req, gpe_set, m_gpe);
         end
      end
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic rd(input string req, input logic [3:0] a);
      cyc(req, 1'b1, 1'b0, a, 4'hF, 32'h0, '0, '0, '0);
   endtask

   task automatic ev(input string req, input logic [31:0] pl, input logic [31:0] ul,
                     input logic [31:0] cl);
      cyc(req, 1'b0, 1'b0, 4'h0, 4'h0, 32'h0, pl, ul, cl);
   endtask

   task automatic wr(input string req, input logic [3:0] a, input logic [31:0] d);
      cyc(req, 1'b1, 1'b1, a, 4'hF, d, '0, '0, '0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      slot_occupied = 32'h0000_0105;
      slot_fixed    = 32'h0000_0001;
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) ev("R1", '0, '0, '0);
      rst_n = 1'b1;
      // R1/R2/R3: reset state through every readable word
      rd("R1", 4'hC);
      rd("R2", 4'h0);
      rd("R3", 4'h4);
      rd("R3", 4'h8);
      // R4: plug slot 3, read in the same cycle shows the old view
      cyc("R4", 1'b1, 1'b0, 4'h0, 4'hF, 0, 32'h8, '0, '0);
      rd("R4", 4'h0);
      ev("R4", 32'h1000, '0, '0);
      ev("R4", 32'h2000, '0, '0);
      rd("R4", 4'h0);
      // R6: cold event, no status pulse
      ev("R6", '0, '0, 32'h200);
      rd("R6", 4'h0);
      rd("R6", 4'h0);
      // R5: removal requests on slots 2 and 8
      ev("R5", '0, 32'h104, '0);
      rd("R5", 4'h4);
      // R7: eject with two bits retires only slot 2
      wr("R7", 4'h8, 32'h104);
      rd("R7", 4'h4);
      rd("R7", 4'h0);
      // R8: slot 4 becomes fixed after reset; eject keeps it present
      slot_fixed = 32'h0000_0011;
      ev("R8", 32'h10, '0, '0);
      ev("R8", '0, 32'h10, '0);
      wr("R8", 4'h8, 32'h10);
      rd("R8", 4'h0);
      rd("R8", 4'h4);
      // R9: eject of zero
      wr("R9", 4'h8, 32'h0);
      rd("R9", 4'h4);
      rd("R9", 4'h0);
      // R10: writes at read-only words
      wr("R10", 4'h0, 32'hFFFF_FFFF);
      wr("R10", 4'h4, 32'hFFFF_FFFF);
      wr("R10", 4'hC, 32'hFFFF_FFFF);
      rd("R10", 4'h4);
      rd("R10", 4'hC);
      // R11: partial and misaligned accesses
      cyc("R11", 1'b1, 1'b1, 4'h8, 4'h7, 32'h100, '0, '0, '0);
      cyc("R11", 1'b1, 1'b1, 4'h9, 4'hF, 32'h100, '0, '0, '0);
      cyc("R11", 1'b1, 1'b0, 4'h4, 4'h3, 32'h0, '0, '0, '0);
      cyc("R11", 1'b1, 1'b0, 4'hE, 4'hF, 32'h0, '0, '0, '0);
      rd("R11", 4'h4);
      // R12: unplug and eject on slot 8 in one cycle
      cyc("R12", 1'b1, 1'b1, 4'h8, 4'hF, 32'h100, '0, 32'h100, '0);
      rd("R12", 4'h4);
      cyc("R12", 1'b1, 1'b1, 4'h8, 4'hF, 32'h100, 32'h100, '0, '0);
      rd("R12", 4'h0);
      rd("R12", 4'h4);
      // R1: second reset with removals pending
      ev("R1", '0, 32'h8000_0000, '0);
      slot_occupied = 32'h8000_0040;
      slot_fixed    = 32'h0000_0040;
      rst_n = 1'b0;
      ev("R1", '0, '0, '0);
      ev("R1", '0, '0, '0);
      rst_n = 1'b1;
      rd("R1", 4'h4);
      rd("R1", 4'h0);
      rd("R1", 4'hC);
      finish_run();
   end
endmodule